// File: doc/BRIEF.md
# Multi-cycle 16-bit RISC core

This block is a small processor core for a 16-bit load/store instruction set. It has eight 16-bit general registers and a two-flag condition register (carry and zero). Register 0 is also the program counter. One memory port serves both instruction fetch and data access. Each instruction runs over several clock cycles: fetch, decode/register read, execute, an optional memory access, and an optional writeback. The instruction decides which of these steps it uses.

Arithmetic and NAND instructions carry a two-bit condition field. When the condition does not hold, the instruction leaves the registers and flags unchanged. Debug outputs expose the whole register file and both flags, so an integrating block or a bench can follow the architectural state.

Top module: `rcore16_top`

## Requirements
- R1: While `rst_ni` is low, all eight registers and both flags are zero, and the first fetch after release reads address 0.
- R2: A fetch drives `mem_addr_o` with R0, latches the word on `mem_rdata_i`, and leaves R0 incremented by one after that cycle.
- R3: Instruction fields are as follows. The opcode is in bits 15:12, RA in 11:9, RB in 8:6 and RC in 5:3. The condition is in bits 1:0. The I-format immediate is bits 5:0 and the J-format immediate is bits 8:0. Both immediates are sign-extended.
- R4: Opcode 0000 writes RA+RB (mod 2^16) into RC. It sets carry to the carry out and zero to (result == 0). It takes 4 cycles.
- R5: Opcode 0010 writes NOT(RA AND RB) into RC and sets zero to (result == 0). Carry is unchanged. It takes 4 cycles.
- R6: The condition field gates opcodes 0000 and 0010. Bit 1 set requires carry = 1, bit 0 set requires zero = 1, and 00 always executes. When the condition fails, no register and no flag changes.
- R7: Opcode 0100 loads RA from memory at RB + imm6 in 5 cycles. Flags are unchanged.
- R8: Opcode 0101 stores RA at RB + imm6. The write enable is high for exactly one cycle, the 4th cycle of the instruction, and is low at all other times.
- R9: Opcode 1100 sets R0 to (address of the instruction) + imm6 when RA equals RB. Otherwise it falls through. It takes 3 cycles.
- R10: Opcode 1000 writes (address of the instruction) + 1 into RA and sets R0 to (address of the instruction) + imm9. It takes 3 cycles. When RA is 0, the jump target wins.
- R11: Any other opcode is a 2-cycle no-op that only advances R0.
- R12: A read of R0 as an operand returns the already-incremented program counter. A write to R0 acts as a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory word address (fetch or data) |
| mem_wdata_o | output | 16 | Store data |
| mem_rdata_i | input | 16 | Read data, combinational from `mem_addr_o` |
| mem_we_o | output | 1 | Store strobe |
| dbg_regs_o | output | 128 | Register file, register n in bits 16n+15:16n |
| dbg_carry_o | output | 1 | Carry flag |
| dbg_zero_o | output | 1 | Zero flag |

## Verification
A suppressed conditional instruction is the hardest case to reach from the ports. It needs a flag left clear by an earlier instruction and then a gated instruction that would visibly change a register. The program therefore chains operations whose results steer the flags deliberately. Examples are an add that overflows to zero, followed by conditional adds and NANDs whose conditions fail one time and hold the next. The program then loops through itself with different register contents. The behavioural model follows every cycle, so wrong latencies, wrong write timing and wrong gating all show up as state mismatches.

// File: rtl/rcore16_pkg.sv
package rcore16_pkg;
  localparam int DW   = 16;
  localparam int NREG = 8;

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_NAND = 4'b0010;
  localparam logic [3:0] OP_LW   = 4'b0100;
  localparam logic [3:0] OP_SW   = 4'b0101;
  localparam logic [3:0] OP_BEQ  = 4'b1100;
  localparam logic [3:0] OP_JAL  = 4'b1000;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB} state_e;
  typedef enum logic {ALU_ADD, ALU_NAND} alu_op_e;
endpackage

// File: rtl/rcore16_regfile.sv
module rcore16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               pc_we_i,
  input  logic [DW-1:0]      pc_wdata_i,
  input  logic [AW-1:0]      raddr_a_i,
  input  logic [AW-1:0]      raddr_b_i,
  output logic [DW-1:0]      rdata_a_o,
  output logic [DW-1:0]      rdata_b_o,
  output logic [DW-1:0]      pc_o,
  output logic [NREG*DW-1:0] dump_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_pc
      // pc port outranks the general port (jump target beats link write)
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           regs_q[g] <= '0;
        else if (pc_we_i)                      regs_q[g] <= pc_wdata_i;
        else if (we_i && waddr_i == AW'(g))    regs_q[g] <= wdata_i;
      end
    end else begin : g_gpr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           regs_q[g] <= '0;
        else if (we_i && waddr_i == AW'(g))    regs_q[g] <= wdata_i;
      end
    end
    assign dump_o[g*DW +: DW] = regs_q[g];
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign pc_o      = regs_q[0];
endmodule

// File: rtl/rcore16_alu.sv
module rcore16_alu
  import rcore16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          zero_o
);
  logic [DW:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (op_i == ALU_ADD) begin
      res_o   = sum[DW-1:0];
      carry_o = sum[DW];
    end else begin
      res_o   = ~(a_i & b_i);
      carry_o = 1'b0;
    end
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/rcore16_ctrl.sv
module rcore16_ctrl
  import rcore16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  output state_e     state_o
);
  state_e state_q, state_d;
  logic is_alu, is_mem, known;

  assign is_alu = (op_i == OP_ADD) || (op_i == OP_NAND);
  assign is_mem = (op_i == OP_LW) || (op_i == OP_SW);
  assign known  = is_alu || is_mem || (op_i == OP_BEQ) || (op_i == OP_JAL);

  always_comb begin
    state_d = S_FETCH;
    unique case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: state_d = known ? S_EXEC : S_FETCH;
      S_EXEC:   state_d = is_alu ? S_WB : (is_mem ? S_MEM : S_FETCH);
      S_MEM:    state_d = (op_i == OP_LW) ? S_WB : S_FETCH;
      S_WB:     state_d = S_FETCH;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rcore16_top.sv
module rcore16_top
  import rcore16_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [DW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               mem_we_o,
  output logic [NREG*DW-1:0] dbg_regs_o,
  output logic               dbg_carry_o,
  output logic               dbg_zero_o
);
  localparam int AW = $clog2(NREG);

  state_e        state_q;
  logic [DW-1:0] ir_q, pc_q, a_q, b_q, res_q, addr_q, ld_q;
  logic          c_res_q, z_res_q, c_q, z_q;

  logic [3:0]    op;
  logic [AW-1:0] ra, rb, rc;
  logic [1:0]    cond;
  logic [DW-1:0] imm6, imm9;
  logic          is_alu, cond_ok;

  assign op     = ir_q[15:12];
  assign ra     = ir_q[11:9];
  assign rb     = ir_q[8:6];
  assign rc     = ir_q[5:3];
  assign cond   = ir_q[1:0];
  assign imm6   = {{(DW-6){ir_q[5]}}, ir_q[5:0]};
  assign imm9   = {{(DW-9){ir_q[8]}}, ir_q[8:0]};
  assign is_alu = (op == OP_ADD) || (op == OP_NAND);
  assign cond_ok = (!cond[1] || c_q) && (!cond[0] || z_q);

  logic [DW-1:0] rd_a, rd_b, pc;
  logic          rf_we, pc_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, pc_wdata;

  rcore16_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .state_o (state_q)
  );

  rcore16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (rf_we),
    .waddr_i    (rf_waddr),
    .wdata_i    (rf_wdata),
    .pc_we_i    (pc_we),
    .pc_wdata_i (pc_wdata),
    .raddr_a_i  (ra),
    .raddr_b_i  (rb),
    .rdata_a_o  (rd_a),
    .rdata_b_o  (rd_b),
    .pc_o       (pc),
    .dump_o     (dbg_regs_o)
  );

  alu_op_e       alu_op;
  logic [DW-1:0] alu_res;
  logic          alu_c, alu_z;
  assign alu_op = (op == OP_NAND) ? ALU_NAND : ALU_ADD;

  rcore16_alu #(.DW(DW)) u_alu (
    .op_i    (alu_op),
    .a_i     (a_q),
    .b_i     (b_q),
    .res_o   (alu_res),
    .carry_o (alu_c),
    .zero_o  (alu_z)
  );

  // Register file write steering
  always_comb begin
    pc_we    = 1'b0;
    pc_wdata = pc + 1'b1;
    rf_we    = 1'b0;
    rf_waddr = rc;
    rf_wdata = res_q;
    unique case (state_q)
      S_FETCH: pc_we = 1'b1;
      S_EXEC: begin
        if (op == OP_BEQ && a_q == b_q) begin
          pc_we    = 1'b1;
          pc_wdata = pc_q + imm6;
        end
        if (op == OP_JAL) begin
          pc_we    = 1'b1;
          pc_wdata = pc_q + imm9;
          rf_we    = 1'b1;
          rf_waddr = ra;
          rf_wdata = pc_q + 1'b1;
        end
      end
      S_WB: begin
        if (op == OP_LW) begin
          rf_we    = 1'b1;
          rf_waddr = ra;
          rf_wdata = ld_q;
        end else if (is_alu && cond_ok) begin
          rf_we = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q    <= '0;
      pc_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      addr_q  <= '0;
      ld_q    <= '0;
      c_res_q <= 1'b0;
      z_res_q <= 1'b0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_FETCH: begin
          ir_q <= mem_rdata_i;
          pc_q <= pc;
        end
        S_DECODE: begin
          a_q <= rd_a;
          b_q <= rd_b;
        end
        S_EXEC: begin
          res_q   <= alu_res;
          c_res_q <= alu_c;
          z_res_q <= alu_z;
          addr_q  <= b_q + imm6;
        end
        S_MEM: ld_q <= mem_rdata_i;
        S_WB: begin
          if (is_alu && cond_ok) begin
            z_q <= z_res_q;
            if (op == OP_ADD) c_q <= c_res_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = (state_q == S_MEM) ? addr_q : pc;
  assign mem_wdata_o = a_q;
  assign mem_we_o    = (state_q == S_MEM) && (op == OP_SW);
  assign dbg_carry_o = c_q;
  assign dbg_zero_o  = z_q;
endmodule

// File: rtl/rcore16_checker.sv
module rcore16_checker
  import rcore16_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input state_e             state_i,
  input logic [DW-1:0]      ir_i,
  input logic [NREG*DW-1:0] regs_i,
  input logic               carry_i,
  input logic               zero_i,
  input logic               we_i
);
  logic [3:0] op;
  logic       alu_op, known, pass;
  assign op     = ir_i[15:12];
  assign alu_op = (op == OP_ADD) || (op == OP_NAND);
  assign known  = alu_op || op == OP_LW || op == OP_SW || op == OP_BEQ || op == OP_JAL;
  assign pass   = (!ir_i[1] || carry_i) && (!ir_i[0] || zero_i);

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FETCH) |=> (regs_i[DW-1:0] == DW'($past(regs_i[DW-1:0]) + 1)));

  a_r8_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (!we_i && state_i == S_FETCH));

  a_r4_flags_only_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != S_WB) |=> $stable({carry_i, zero_i}));

  a_r5_nand_keeps_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_WB && op == OP_NAND) |=> $stable(carry_i));

  a_r6_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_WB && alu_op && !pass) |=> $stable({regs_i, carry_i, zero_i}));

  a_r11_unknown_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DECODE && !known) |=> (state_i == S_FETCH && $stable(regs_i)));
endmodule

bind rcore16_top rcore16_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (state_q),
  .ir_i    (ir_q),
  .regs_i  (dbg_regs_o),
  .carry_i (dbg_carry_o),
  .zero_i  (dbg_zero_o),
  .we_i    (mem_we_o)
);

// File: tb/rcore16_top_bench.sv
module rcore16_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0]  mem [256];
  logic [15:0]  addr, wdata, rdata;
  logic         we, c, z;
  logic [127:0] regs;

  rcore16_top u_rcore16_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .mem_we_o    (we),
    .dbg_regs_o  (regs),
    .dbg_carry_o (c),
    .dbg_zero_o  (z)
  );

  assign rdata = mem[addr[7:0]];
  always @(posedge clk) if (we) mem[addr[7:0]] <= wdata;

  int errors = 0;
  int checks = 0;
  logic [7:0][15:0] ref_r;
  logic ref_c, ref_z;

  task automatic check(input string tag, input logic [129:0] act, input logic [129:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R3: field layout used to build the program
  function automatic logic [15:0] enc_r(input logic [3:0] op, input int a, b, d, input logic [1:0] cd);
    return {op, 3'(a), 3'(b), 3'(d), 1'b0, cd};
  endfunction
  function automatic logic [15:0] enc_i(input logic [3:0] op, input int a, b, imm);
    logic [5:0] i6 = 6'(imm);
    return {op, 3'(a), 3'(b), i6};
  endfunction
  function automatic logic [15:0] enc_j(input logic [3:0] op, input int a, imm);
    logic [8:0] i9 = 9'(imm);
    return {op, 3'(a), i9};
  endfunction

  task automatic step();
    logic [15:0] pc, ir, a, b, ea, sw_d;
    logic [7:0][15:0] pre, post;
    logic [16:0] sum;
    logic [15:0] res;
    logic [3:0] op;
    logic [2:0] ra, rb, rc;
    logic [1:0] cd;
    logic pc_, pz, ok, is_sw;
    int lat;
    string tag;
    pc = ref_r[0];
    ir = mem[pc[7:0]];
    op = ir[15:12]; ra = ir[11:9]; rb = ir[8:6]; rc = ir[5:3]; cd = ir[1:0];
    pre = ref_r; pre[0] = pc + 16'd1;
    post = pre; pc_ = ref_c; pz = ref_z;
    a = post[ra]; b = post[rb];           // R12: operands see incremented R0
    ea = b + {{10{ir[5]}}, ir[5:0]};
    ok = (!cd[1] || ref_c) && (!cd[0] || ref_z);
    is_sw = 1'b0; sw_d = a;
    case (op)
      4'b0000: begin
        lat = 4; tag = ok ? "R4" : "R6";
        sum = {1'b0, a} + {1'b0, b};
        if (ok) begin post[rc] = sum[15:0]; pc_ = sum[16]; pz = (sum[15:0] == 0); end
      end
      4'b0010: begin
        lat = 4; tag = ok ? "R5" : "R6";
        res = ~(a & b);
        if (ok) begin post[rc] = res; pz = (res == 0); end
      end
      4'b0100: begin lat = 5; tag = "R7"; post[ra] = mem[ea[7:0]]; end
      4'b0101: begin lat = 4; tag = "R8"; is_sw = 1'b1; end
      4'b1100: begin
        lat = 3; tag = "R9";
        if (a == b) post[0] = pc + {{10{ir[5]}}, ir[5:0]};
      end
      4'b1000: begin
        lat = 3; tag = "R10";
        post[ra] = pc + 16'd1;
        post[0]  = pc + {{7{ir[8]}}, ir[8:0]};
      end
      default: begin lat = 2; tag = "R11"; end
    endcase
    check("R2 fetch address", {114'd0, addr}, {114'd0, pc});
    for (int k = 1; k <= lat; k++) begin
      if (k == lat && is_sw)
        check("R8 store strobe", {97'd0, we, addr, wdata}, {97'd0, 1'b1, ea, sw_d});
      else
        check("R8 no store", {129'd0, we}, 130'd0);
      @(posedge clk); @(negedge clk);
      if (k < lat) check({tag, " mid"}, {regs, c, z}, {pre, ref_c, ref_z});
      else         check({tag, " end"}, {regs, c, z}, {post, pc_, pz});
    end
    ref_r = post; ref_c = pc_; ref_z = pz;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = enc_i(4'b0100, 6, 7, 31);
    mem[1]  = enc_i(4'b0100, 1, 6, 0);
    mem[2]  = enc_i(4'b0100, 2, 6, 1);
    mem[3]  = enc_r(4'b0000, 1, 2, 3, 2'b00);   // FFFF+1: C=1 Z=1
    mem[4]  = enc_r(4'b0000, 2, 2, 4, 2'b10);   // carry set: executes
    mem[5]  = enc_r(4'b0000, 2, 2, 5, 2'b10);   // carry clear: suppressed
    mem[6]  = enc_r(4'b0010, 1, 2, 5, 2'b00);
    mem[7]  = enc_r(4'b0010, 1, 1, 4, 2'b01);   // zero clear: suppressed
    mem[8]  = enc_r(4'b0010, 1, 1, 3, 2'b00);   // result 0: Z=1
    mem[9]  = enc_r(4'b0010, 2, 2, 4, 2'b01);   // zero set: executes
    mem[10] = enc_i(4'b0101, 5, 6, 2);
    mem[11] = enc_i(4'b0100, 3, 6, 2);
    mem[12] = enc_i(4'b1100, 3, 5, 2);          // taken
    mem[13] = enc_r(4'b0000, 1, 1, 1, 2'b00);   // skipped
    mem[14] = enc_i(4'b1100, 1, 2, 5);          // not taken
    mem[15] = enc_r(4'b0000, 0, 7, 4, 2'b00);   // reads R0
    mem[16] = 16'hF000;
    mem[17] = enc_j(4'b1000, 7, 2);
    mem[18] = 16'hFFFF;
    mem[19] = enc_j(4'b1000, 1, -19);
    mem[31] = 16'h0080; mem[48] = 16'h0080; mem[49] = 16'h0080;
    mem[128] = 16'hFFFF; mem[129] = 16'h0001;

    ref_r = '0; ref_c = 1'b0; ref_z = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", {regs, c, z}, 130'd0);
    check("R1 first fetch", {114'd0, addr}, 130'd0);
    rst_n = 1'b1;
    for (int n = 0; n < 45; n++) step();

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", {regs, c, z}, 130'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_r = '0; ref_c = 1'b0; ref_z = 1'b0;
    for (int n = 0; n < 5; n++) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule